// File: doc/BRIEF.md
# IP Cell Next-Hop Header Rewriter

This block sits in a 32-bit word-serial ATM cell path. A cell is fourteen words long: a header word, a pad word and twelve payload words. Every accepted cell goes into an internal cell queue. The block compares the virtual-circuit field of each header with a configured circuit number. A cell on that circuit is an IP cell; every other cell is ordinary traffic.

For the first cell of an IP packet, the block reads the IPv4 destination address from the seventh word and pushes it into an external lookup-request queue. When that cell reaches the head of the cell queue, the block pops the matching next hop from an external result queue. It writes the next hop into the circuit field of the outgoing header. The next hop is also kept, so that the later cells of the same packet leave on the same circuit without a second lookup.

All cells leave in the order they arrived. An IP cell that is still waiting for its lookup result therefore also holds back the ordinary cells queued behind it. Flow control uses a cell-available signal on each side: the block gives one to its upstream and obeys the one from downstream.

Top module: `atm_ip_rewriter`

## Requirements
- R1: After reset, out_soc, req_wr and nh_rd are 0, and in_tca is 1 as long as req_full is 0.
- R2: An accepted input cell is in_soc with word 0 followed by 13 consecutive words. Each output cell is 14 consecutive words, with out_soc high on word 0 only, and cells leave in their arrival order.
- R3: A cell whose header bits [19:4] differ from cfg_ip_vci leaves with all 14 words bit-identical.
- R4: For the first cell of an IP packet, word index 6 (the seventh word) appears on req_addr with a single-cycle req_wr pulse.
- R5: The header of an IP cell leaves with bits [19:4] replaced by its next hop. Bits [31:20] and [3:0] are kept, and payload words are unchanged.
- R6: Header bit 1 marks the last cell of a packet. Later IP cells of a packet reuse the latched next hop, with no request and no pop. Ordinary cells between them do not disturb this.
- R7: An IP cell that needs a next hop does not start while nh_empty is 1. Cells behind it do not overtake it, and its lookup request has already been issued.
- R8: No output cell starts while out_tca is 0.
- R9: in_tca is 0 while the cell queue lacks room for a full cell or req_full is 1. A cell whose in_soc arrives while in_tca is 0 is discarded entirely.
- R10: The circuit number on cfg_ip_vci selects which cells are treated as IP cells; cells on any other circuit pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ip_vci | input | 16 | Circuit number that carries IP packets |
| in_soc | input | 1 | Start of an input cell (word 0) |
| in_data | input | 32 | Input cell word |
| in_tca | output | 1 | Block can accept a new cell this cycle |
| out_soc | output | 1 | Start of an output cell (word 0) |
| out_data | output | 32 | Output cell word, zero between cells |
| out_tca | input | 1 | Downstream can accept a new cell |
| req_wr | output | 1 | Push a destination address into the lookup-request queue |
| req_addr | output | 32 | Destination address being pushed |
| req_full | input | 1 | Lookup-request queue is full |
| nh_rd | output | 1 | Pop the head of the next-hop queue |
| nh_data | input | 16 | Head of the next-hop queue |
| nh_empty | input | 1 | Next-hop queue is empty |

## Verification
A sweep of IP headers varies the GFC, VPI, PTI and CLP bits together with the next hop. Any error that leaks a bit outside the circuit field, or that clips the field, shows up in one of those headers. A three-cell packet with an ordinary cell inside it separates reuse of the latched next hop from a fresh pop, and a single-cell packet that follows shows whether the latch is replaced. Withholding the next hop, the downstream cell-available signal and the queue space in turn shows stalling, ordering, backpressure and dropping of an unpermitted cell as separate effects. A change of the configured circuit shows that the match follows the port and not a fixed value.

// File: rtl/atmr_pkg.sv
package atmr_pkg;
  localparam int WORD_W  = 32;
  localparam int VCI_W   = 16;
  localparam int VCI_LO  = 4;   // circuit field sits at header bits [19:4]
  localparam int EOP_BIT = 1;   // last-cell marker in the header

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [VCI_W-1:0]  vci_t;

  typedef struct packed {
    logic  ip;
    logic  first;
    word_t w;
  } cell_ent_t;

  function automatic vci_t hdr_vci(word_t h);
    return h[VCI_LO +: VCI_W];
  endfunction

  function automatic logic hdr_eop(word_t h);
    return h[EOP_BIT];
  endfunction

  function automatic word_t hdr_put_vci(word_t h, vci_t v);
    word_t r;
    r = h;
    r[VCI_LO +: VCI_W] = v;
    return r;
  endfunction
endpackage

// File: rtl/atmr_cell_fifo.sv
module atmr_cell_fifo
  import atmr_pkg::*;
#(
  parameter  int DEPTH = 56,
  localparam int AW    = $clog2(DEPTH),
  localparam int OW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  cell_ent_t     wr_ent,
  input  logic          rd_en,
  output cell_ent_t     rd_ent,
  output logic [OW-1:0] occ
);
  cell_ent_t         mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (wr_en) wp <= ptr_next(wp);
      if (rd_en) rp <= ptr_next(rp);
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + OW'(1);
        2'b01:   occ <= occ - OW'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign rd_ent = mem[rp];

  // R9: the entry gate upstream keeps the queue from overflowing
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (occ < OW'(DEPTH)));
  // R2: the egress never reads past the words it has been given
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (occ != '0));
endmodule

// File: rtl/atmr_ingress.sv
module atmr_ingress
  import atmr_pkg::*;
#(
  parameter  int CELL_WORDS = 14,
  parameter  int DA_IDX     = 6,
  parameter  int DEPTH      = 56,
  localparam int CW         = $clog2(CELL_WORDS),
  localparam int OW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vci_t          cfg_ip_vci,
  input  logic          in_soc,
  input  word_t         in_data,
  output logic          in_tca,
  input  logic          req_full,
  output logic          req_wr,
  output word_t         req_addr,
  input  logic [OW-1:0] occ,
  output logic          fifo_wr,
  output cell_ent_t     fifo_ent,
  output logic          cell_done
);
  logic [CW-1:0] rx_cnt;
  logic          rx_keep, rx_first, rx_mid;
  logic          rx_idle, room, hdr_ip;
  logic          take_hdr, drop_hdr, body_wr;

  assign rx_idle  = (rx_cnt == '0);
  assign room     = (occ <= OW'(DEPTH - CELL_WORDS));
  assign hdr_ip   = (hdr_vci(in_data) == cfg_ip_vci);
  assign in_tca   = rx_idle && room && !req_full;

  // named events for the checks below
  assign take_hdr = in_soc && in_tca;
  assign drop_hdr = in_soc && rx_idle && !in_tca;
  assign body_wr  = !rx_idle && rx_keep;

  assign fifo_wr   = take_hdr || body_wr;
  assign req_wr    = body_wr && rx_first && (rx_cnt == CW'(DA_IDX));
  assign req_addr  = in_data;
  assign cell_done = body_wr && (rx_cnt == CW'(CELL_WORDS - 1));

  always_comb begin
    fifo_ent.w     = in_data;
    fifo_ent.ip    = take_hdr && hdr_ip;
    fifo_ent.first = take_hdr && hdr_ip && !rx_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt   <= '0;
      rx_keep  <= 1'b0;
      rx_first <= 1'b0;
      rx_mid   <= 1'b0;
    end else if (take_hdr || drop_hdr) begin
      rx_cnt   <= CW'(1);
      rx_keep  <= take_hdr;
      rx_first <= take_hdr && hdr_ip && !rx_mid;
      if (take_hdr && hdr_ip) rx_mid <= !hdr_eop(in_data);
    end else if (!rx_idle) begin
      rx_cnt <= (rx_cnt == CW'(CELL_WORDS - 1)) ? '0 : rx_cnt + CW'(1);
    end
  end

  // R9: a refused cell leaves nothing in the queue
  a_r9_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    drop_hdr |=> !fifo_wr);
  // R4: the request queue had room when the cell was admitted
  a_r4_req_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |-> !req_full);
  // R4: one key per packet, never two in a row
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> !req_wr);
endmodule

// File: rtl/atmr_egress.sv
module atmr_egress
  import atmr_pkg::*;
#(
  parameter  int CELL_WORDS = 14,
  parameter  int FIFO_CELLS = 4,
  localparam int CW         = $clog2(CELL_WORDS),
  localparam int NW         = $clog2(FIFO_CELLS + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cell_ent_t head,
  input  logic      cell_done,
  output logic      fifo_rd,
  input  logic      out_tca,
  input  logic      nh_empty,
  input  vci_t      nh_data,
  output logic      nh_rd,
  output logic      out_soc,
  output word_t     out_data
);
  logic [CW-1:0] tx_cnt;
  logic [NW-1:0] ready_cells;
  vci_t          held_nh, use_nh;
  word_t         hdr_out;
  logic          tx_idle, tx_start;

  assign tx_idle  = (tx_cnt == '0);
  assign tx_start = tx_idle && (ready_cells != '0) && out_tca &&
                    (!head.first || !nh_empty);
  assign fifo_rd  = tx_start || !tx_idle;
  assign nh_rd    = tx_start && head.first;
  assign use_nh   = head.first ? nh_data : held_nh;
  assign hdr_out  = head.ip ? hdr_put_vci(head.w, use_nh) : head.w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt      <= '0;
      ready_cells <= '0;
      held_nh     <= '0;
      out_soc     <= 1'b0;
      out_data    <= '0;
    end else begin
      ready_cells <= ready_cells + NW'(cell_done) - NW'(tx_start);
      if (nh_rd) held_nh <= nh_data;
      if (tx_start) begin
        out_soc  <= 1'b1;
        out_data <= hdr_out;
        tx_cnt   <= CW'(1);
      end else if (!tx_idle) begin
        out_soc  <= 1'b0;
        out_data <= head.w;
        tx_cnt   <= (tx_cnt == CW'(CELL_WORDS - 1)) ? '0 : tx_cnt + CW'(1);
      end else begin
        out_soc  <= 1'b0;
        out_data <= '0;
      end
    end
  end

  // R7: a next hop is popped only when one is present
  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    nh_rd |-> !nh_empty);
  // R8: every cell start was permitted by downstream
  a_r8_tca_before_soc: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> $past(out_tca));
  // R2: word 0 is never followed directly by another word 0
  a_r2_soc_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |=> !out_soc);
  // R9: no more complete cells than the queue can hold
  a_r9_cells_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ready_cells <= NW'(FIFO_CELLS));
endmodule

// File: rtl/atm_ip_rewriter.sv
module atm_ip_rewriter
  import atmr_pkg::*;
#(
  parameter  int CELL_WORDS = 14,
  parameter  int DA_IDX     = 6,
  parameter  int FIFO_CELLS = 4,
  localparam int DEPTH      = FIFO_CELLS * CELL_WORDS,
  localparam int OW         = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_ip_vci,
  input  logic        in_soc,
  input  logic [31:0] in_data,
  output logic        in_tca,
  output logic        out_soc,
  output logic [31:0] out_data,
  input  logic        out_tca,
  output logic        req_wr,
  output logic [31:0] req_addr,
  input  logic        req_full,
  output logic        nh_rd,
  input  logic [15:0] nh_data,
  input  logic        nh_empty
);
  cell_ent_t     wr_ent, head;
  logic          fifo_wr, fifo_rd, cell_done;
  logic [OW-1:0] occ;

  atmr_ingress #(.CELL_WORDS(CELL_WORDS), .DA_IDX(DA_IDX), .DEPTH(DEPTH)) u_ingress (
    .clk(clk), .rst_n(rst_n), .cfg_ip_vci(cfg_ip_vci),
    .in_soc(in_soc), .in_data(in_data), .in_tca(in_tca),
    .req_full(req_full), .req_wr(req_wr), .req_addr(req_addr),
    .occ(occ), .fifo_wr(fifo_wr), .fifo_ent(wr_ent), .cell_done(cell_done)
  );

  atmr_cell_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_ent(wr_ent),
    .rd_en(fifo_rd), .rd_ent(head), .occ(occ)
  );

  atmr_egress #(.CELL_WORDS(CELL_WORDS), .FIFO_CELLS(FIFO_CELLS)) u_egress (
    .clk(clk), .rst_n(rst_n), .head(head), .cell_done(cell_done),
    .fifo_rd(fifo_rd), .out_tca(out_tca), .nh_empty(nh_empty),
    .nh_data(nh_data), .nh_rd(nh_rd), .out_soc(out_soc), .out_data(out_data)
  );
endmodule

// File: tb/atm_ip_rewriter_bench.sv
module atm_ip_rewriter_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_soc, in_tca, out_soc, out_tca, req_wr, req_full, nh_rd, nh_empty;
  logic [15:0] cfg_ip_vci, nh_data;
  logic [31:0] in_data, out_data, req_addr;

  atm_ip_rewriter u_atm_ip_rewriter (
    .clk(clk), .rst_n(rst_n), .cfg_ip_vci(cfg_ip_vci), .in_soc(in_soc), .in_data(in_data),
    .in_tca(in_tca), .out_soc(out_soc), .out_data(out_data), .out_tca(out_tca),
    .req_wr(req_wr), .req_addr(req_addr), .req_full(req_full), .nh_rd(nh_rd),
    .nh_data(nh_data), .nh_empty(nh_empty)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pw(int k, logic [7:0] s, logic [31:0] da);
    if (k == 6) return da;
    return {s, 8'(k), ~s, 8'(k) ^ 8'h3C};
  endfunction

  function automatic logic [31:0] mk(logic [3:0] g, logic [7:0] p, logic [15:0] v,
                                     logic [2:0] t, logic c);
    return {g, p, v, t, c};
  endfunction

  // next-hop queue model
  logic [15:0] nh_q [0:63];
  int nh_wr = 0, nh_ptr = 0;
  bit nh_gate = 1'b0;
  assign nh_empty = nh_gate || (nh_ptr == nh_wr);
  assign nh_data  = nh_q[nh_ptr[5:0]];
  always @(posedge clk) if (nh_rd) nh_ptr <= nh_ptr + 1;

  task automatic push_nh(input logic [15:0] v);
    nh_q[nh_wr[5:0]] = v;
    nh_wr++;
  endtask

  // expected lookup keys
  logic [31:0] rq_exp [0:63];
  int rq_wr = 0, rq_rd = 0;
  task automatic expect_req(input logic [31:0] a);
    rq_exp[rq_wr[5:0]] = a;
    rq_wr++;
  endtask

  // expected output cells
  logic [31:0] ex_hdr [0:63];
  logic [31:0] ex_da  [0:63];
  logic [7:0]  ex_s   [0:63];
  string       ex_rq  [0:63];
  int ex_wr = 0, ex_rd = 0, cells_out = 0, mon_k = 0;
  logic [31:0] mon_w [0:13];
  bit mon_soc_bad = 1'b0;

  always @(negedge clk) begin
    #2;
    if (req_wr) begin
      if (rq_rd < rq_wr) chk(req_addr == rq_exp[rq_rd[5:0]], "R4", "lookup key", req_addr, rq_exp[rq_rd[5:0]]);
      else chk(1'b0, "R6", "unexpected lookup request", req_addr, 32'h0);
      rq_rd++;
    end
    if (mon_k == 0) begin
      if (out_soc) begin mon_w[0] = out_data; mon_k = 1; mon_soc_bad = 1'b0; end
    end else begin
      mon_w[mon_k] = out_data;
      if (out_soc) mon_soc_bad = 1'b1;
      mon_k++;
      if (mon_k == 14) begin
        mon_k = 0;
        cells_out++;
        if (ex_rd >= ex_wr) chk(1'b0, "R2", "unexpected output cell", mon_w[0], 32'h0);
        else begin
          logic [31:0] a, e;
          bit ok;
          ok = (mon_w[0] == ex_hdr[ex_rd[5:0]]) && !mon_soc_bad;
          a = mon_w[0]; e = ex_hdr[ex_rd[5:0]];
          for (int k = 1; k < 14; k++) begin
            if (ok && mon_w[k] != pw(k, ex_s[ex_rd[5:0]], ex_da[ex_rd[5:0]])) begin
              ok = 1'b0; a = mon_w[k]; e = pw(k, ex_s[ex_rd[5:0]], ex_da[ex_rd[5:0]]);
            end
          end
          chk(ok, ex_rq[ex_rd[5:0]], "output cell", a, e);
          ex_rd++;
        end
      end
    end
  end

  task automatic send_cell(input logic [31:0] hdr, input logic [31:0] da, input logic [7:0] s,
                           input bit force_it, input int nh_exp, input string rq);
    @(negedge clk);
    if (!force_it) begin
      while (!in_tca) @(negedge clk);
      ex_hdr[ex_wr[5:0]] = (nh_exp < 0) ? hdr : {hdr[31:20], nh_exp[15:0], hdr[3:0]};
      ex_da[ex_wr[5:0]]  = da;
      ex_s[ex_wr[5:0]]   = s;
      ex_rq[ex_wr[5:0]]  = rq;
      ex_wr++;
    end
    in_soc  = 1'b1;
    in_data = hdr;
    for (int k = 1; k < 14; k++) begin
      @(negedge clk);
      in_soc  = 1'b0;
      in_data = pw(k, s, da);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && ex_rd != ex_wr; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", ex_rd, ex_wr);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; in_soc = 1'b0; in_data = '0; out_tca = 1'b1;
    req_full = 1'b0; cfg_ip_vci = 16'h003E;
    repeat (3) @(negedge clk);
    #2;
    chk(out_soc == 1'b0, "R1", "out_soc in reset", 32'(out_soc), 32'h0);
    chk(req_wr == 1'b0 && nh_rd == 1'b0, "R1", "req_wr/nh_rd in reset", {30'h0, req_wr, nh_rd}, 32'h0);
    chk(in_tca == 1'b1, "R1", "in_tca in reset", 32'(in_tca), 32'h1);
    rst_n = 1'b1;

    // R3: ordinary traffic, no next hop ever available
    nh_gate = 1'b1;
    send_cell(mk(4'hF, 8'hFF, 16'h0000, 3'b000, 1'b1), 32'h01020304, 8'h11, 1'b0, -1, "R3");
    send_cell(mk(4'h0, 8'h00, 16'h0001, 3'b001, 1'b0), 32'hFFFFFFFF, 8'h22, 1'b0, -1, "R3");
    send_cell(mk(4'hA, 8'h5A, 16'h003F, 3'b111, 1'b1), 32'h0ABAC000, 8'h33, 1'b0, -1, "R3");
    send_cell(mk(4'h5, 8'hA5, 16'hFFFF, 3'b010, 1'b0), 32'h00000000, 8'h44, 1'b0, -1, "R3");
    send_cell(mk(4'h3, 8'h3C, 16'h003D, 3'b100, 1'b1), 32'hC0A80001, 8'h55, 1'b0, -1, "R3");
    drain();
    nh_gate = 1'b0;

    // R4, R5: single-cell IP packets sweeping every other header bit
    for (int i = 0; i < 8; i++) begin
      logic [2:0]  b;
      logic [15:0] nh;
      logic [31:0] da;
      b  = 3'(i);
      nh = 16'h0004 + 16'(i * 4657);
      da = 32'h0ABAA000 + 32'(i * 32'h01010101);
      push_nh(nh);
      expect_req(da);
      send_cell(mk(4'(i * 5), 8'(i * 37 + 5), 16'h003E, {b[2:1], 1'b1}, b[0]), da,
                8'(8'h60 + i), 1'b0, int'(nh), "R5");
    end
    drain();
    chk(rq_rd == rq_wr, "R4", "lookup key count", 32'(rq_rd), 32'(rq_wr));

    // R6: three-cell packet with an ordinary cell inside it, then a fresh packet
    push_nh(16'h003F);
    expect_req(32'h0ABAC000);
    send_cell(mk(4'h1, 8'h02, 16'h003E, 3'b000, 1'b0), 32'h0ABAC000, 8'h71, 1'b0, 16'h003F, "R6");
    send_cell(mk(4'h1, 8'h02, 16'h0200, 3'b000, 1'b0), 32'h12345678, 8'h72, 1'b0, -1, "R6");
    send_cell(mk(4'h1, 8'h02, 16'h003E, 3'b000, 1'b1), 32'h11112222, 8'h73, 1'b0, 16'h003F, "R6");
    send_cell(mk(4'h1, 8'h02, 16'h003E, 3'b001, 1'b0), 32'h33334444, 8'h74, 1'b0, 16'h003F, "R6");
    push_nh(16'h0022);
    expect_req(32'hDA800000);
    send_cell(mk(4'h2, 8'h09, 16'h003E, 3'b001, 1'b0), 32'hDA800000, 8'h75, 1'b0, 16'h0022, "R6");
    drain();
    chk(nh_ptr == nh_wr, "R6", "next hops popped", 32'(nh_ptr), 32'(nh_wr));
    chk(rq_rd == rq_wr, "R6", "lookup requests", 32'(rq_rd), 32'(rq_wr));

    // R7: IP cell waits for its next hop and an ordinary cell waits behind it
    nh_gate = 1'b1;
    push_nh(16'h0006);
    expect_req(32'h80000000);
    c0 = cells_out;
    send_cell(mk(4'h0, 8'h00, 16'h003E, 3'b001, 1'b0), 32'h80000000, 8'h81, 1'b0, 16'h0006, "R7");
    send_cell(mk(4'h7, 8'h77, 16'h0123, 3'b000, 1'b0), 32'h0BADF00D, 8'h82, 1'b0, -1, "R7");
    repeat (60) @(negedge clk);
    #2;
    chk(cells_out == c0, "R7", "cells out while next hop missing", 32'(cells_out), 32'(c0));
    chk(rq_rd == rq_wr, "R7", "request issued while stalled", 32'(rq_rd), 32'(rq_wr));
    nh_gate = 1'b0;
    drain();
    chk(cells_out == c0 + 2, "R7", "cells out after release", 32'(cells_out), 32'(c0 + 2));

    // R8: downstream refuses
    out_tca = 1'b0;
    c0 = cells_out;
    send_cell(mk(4'h9, 8'h19, 16'h0456, 3'b000, 1'b1), 32'h00C0FFEE, 8'h91, 1'b0, -1, "R8");
    repeat (40) @(negedge clk);
    #2;
    chk(cells_out == c0 && mon_k == 0, "R8", "cells out while out_tca low", 32'(cells_out), 32'(c0));
    out_tca = 1'b1;
    drain();

    // R9: fill the queue, refuse and drop, then request-queue backpressure
    out_tca = 1'b0;
    c0 = cells_out;
    for (int i = 0; i < 4; i++)
      send_cell(mk(4'hB, 8'(i), 16'h0700, 3'b000, 1'b0), 32'(i), 8'(8'hA0 + i), 1'b0, -1, "R9");
    @(negedge clk);
    #2;
    chk(in_tca == 1'b0, "R9", "in_tca with full queue", 32'(in_tca), 32'h0);
    send_cell(mk(4'hE, 8'hEE, 16'h0701, 3'b000, 1'b0), 32'hDEADBEEF, 8'hEE, 1'b1, -1, "R9");
    @(negedge clk);
    #2;
    chk(in_tca == 1'b0, "R9", "in_tca after refused cell", 32'(in_tca), 32'h0);
    out_tca = 1'b1;
    drain();
    repeat (40) @(negedge clk);
    #2;
    chk(cells_out == c0 + 4, "R9", "cells out after drop", 32'(cells_out), 32'(c0 + 4));
    chk(in_tca == 1'b1, "R9", "in_tca after drain", 32'(in_tca), 32'h1);
    req_full = 1'b1;
    @(negedge clk);
    #2;
    chk(in_tca == 1'b0, "R9", "in_tca with request queue full", 32'(in_tca), 32'h0);
    req_full = 1'b0;

    // R10: move the IP circuit
    cfg_ip_vci = 16'h0064;
    send_cell(mk(4'h4, 8'h44, 16'h003E, 3'b001, 1'b0), 32'h0ABAA000, 8'hC1, 1'b0, -1, "R10");
    push_nh(16'h004D);
    expect_req(32'h0ABAA000);
    send_cell(mk(4'h4, 8'h44, 16'h0064, 3'b001, 1'b1), 32'h0ABAA000, 8'hC2, 1'b0, 16'h004D, "R10");
    drain();
    chk(rq_rd == rq_wr, "R10", "lookup requests", 32'(rq_rd), 32'(rq_wr));
    chk(nh_ptr == nh_wr, "R10", "next hops popped", 32'(nh_ptr), 32'(nh_wr));
    chk(ex_rd == ex_wr, "R2", "all expected cells seen", 32'(ex_rd), 32'(ex_wr));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule